// File: doc/BRIEF.md
# Matrix Tile Slice Pair Extractor

This block keeps a square matrix store of 16 rows by 128 bits and answers one kind of request: copy two neighbouring slices of a chosen tile into a pair of 128-bit vector results. A slice is either a row of the tile (horizontal) or a column of the tile (vertical). Elements are 8, 16, 32 or 64 bits wide. For the wider sizes the store holds 2, 4 or 8 tiles, and their rows are interleaved.

A request is a 32-bit instruction word presented with a one-cycle `start` strobe. Four 32-bit scalar index values come in beside it. The first slice number is the chosen index value plus an even immediate offset, wrapped to the tile dimension. The second slice is the next number, also wrapped. One cycle after `start`, `done` pulses. The two slice vectors and the two destination register numbers then hold until the next request. A row-write port loads the store.

Top module: `tile_slice_mover`

## Requirements
- R1: A start whose word breaks any fixed field is illegal. The fixed fields are bits 31:24 = 0xC0, bits 21:16 = 000110, bits 12:8 = 00000 and bit 0 = 0. An illegal start raises `illegal` together with `done`, and leaves `res_lo`, `res_hi`, `dst_lo` and `dst_hi` unchanged. A legal start clears `illegal`.
- R2: Bits 23:22 select the element size: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. The tile dimension is 16, 8, 4 or 2 accordingly. Tile t of element width E bytes owns store rows E·i+t, where i is the tile row. Tile element j of a row occupies bits [j·8E +: 8E].
- R3: With bit 15 = 0, each result is the whole store row that holds tile row s, where s is that result's slice number.
- R4: With bit 15 = 1, element i of each result is element s of tile row i, for every tile row i.
- R5: Bits 14:13 = k select index value k, taken from `idx_regs[32k +: 32]`. The other three index values have no effect.
- R6: The immediate offset is twice the field value. The field is bits 7:5 for 8-bit elements, bits 6:5 for 16-bit and bit 5 for 32-bit. The offset is 0 for 64-bit.
- R7: The tile number is 0 for 8-bit elements. It is bit 7 for 16-bit, bits 7:6 for 32-bit and bits 7:5 for 64-bit.
- R8: The slice for `res_lo` is (index + offset) mod dimension. The slice for `res_hi` is (that value + 1) mod dimension.
- R9: Bits 4:1 = z give `dst_lo` = 2z and `dst_hi` = 2z+1.
- R10: `done` is high exactly in the cycle after a start and for one cycle only. The results hold their values while no start is given.
- R11: When `wr_en` is high, `wr_data` is written into row `wr_row` at the clock edge. A start in the same cycle as a write returns the contents from before that write.
- R12: A synchronous active-low reset clears the store, both results, both destinations, `done` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Row write enable |
| wr_row | input | 4 | Row written |
| wr_data | input | 128 | Row write data |
| start | input | 1 | Request strobe, one cycle |
| instr | input | 32 | Instruction word |
| idx_regs | input | 128 | Four 32-bit index values; value k at bits [32k +: 32] |
| res_lo | output | 128 | First slice vector |
| res_hi | output | 128 | Second slice vector |
| dst_lo | output | 5 | First destination register number |
| dst_hi | output | 5 | Second destination register number |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Last request was illegal |

## Verification
A row write and a slice read can land in the same cycle. To provoke this, the bench raises `wr_en` for row 0 in the same cycle as a start that reads horizontal slice 0. It then expects the row's old contents in `res_lo`. A second read right after that expects the new data. This shows the write took effect at the edge without disturbing the read that overlapped it.

// File: rtl/tsx_pkg.sv
// Shared types for the tile slice pair extractor.
// Assumes a 32-bit instruction word and element sizes of 8 to 64 bits.
package tsx_pkg;
    localparam int IW   = 32;   // instruction width
    localparam int XW   = 32;   // scalar index width
    localparam int NIDX = 4;    // index values offered

    // Decoded request
    typedef struct packed {
        logic       legal;
        logic [1:0] esize;   // 0:8b 1:16b 2:32b 3:64b
        logic       vert;    // 1 = column slice
        logic [1:0] rsel;    // index value chosen
        logic [3:0] zd;      // destination pair number
        logic [2:0] tile;    // tile number, already masked to size
        logic [3:0] off;     // scaled immediate offset
    } req_t;
endpackage

// File: rtl/tsx_decode.sv
// Instruction decoder: checks the fixed fields and unpacks size, direction,
// index select, tile, offset and destination. Purely combinational.
// Assumes reserved bit 8 must be zero for every size.
module tsx_decode
    import tsx_pkg::*;
(
    input  logic [IW-1:0] instr_i,
    output req_t          req_o
);
    // Unpack fields and judge legality
    always_comb begin
        req_o       = '0;
        req_o.legal = (instr_i[31:24] == 8'hC0) && (instr_i[21:16] == 6'b000110)
                   && (instr_i[12:8] == 5'b00000) && !instr_i[0];
        req_o.esize = instr_i[23:22];
        req_o.vert  = instr_i[15];
        req_o.rsel  = instr_i[14:13];
        req_o.zd    = instr_i[4:1];
        case (instr_i[23:22])
            2'd0: begin
                req_o.tile = 3'd0;
                req_o.off  = {instr_i[7:5], 1'b0};
            end
            2'd1: begin
                req_o.tile = {2'b00, instr_i[7]};
                req_o.off  = {1'b0, instr_i[6:5], 1'b0};
            end
            2'd2: begin
                req_o.tile = {1'b0, instr_i[7:6]};
                req_o.off  = {2'b00, instr_i[5], 1'b0};
            end
            default: begin
                req_o.tile = instr_i[7:5];
                req_o.off  = 4'd0;
            end
        endcase
    end
endmodule

// File: rtl/tsx_slice_index.sv
// Slice number generator: picks one index value, adds the offset and wraps
// both the slice and its successor to the tile dimension of the element size.
// Assumes ROWS is a power of two and at least 8.
module tsx_slice_index
    import tsx_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int SW  = $clog2(ROWS)
) (
    input  logic [NIDX*XW-1:0] idx_i,
    input  req_t               req_i,
    output logic [SW-1:0]      slice0_o,
    output logic [SW-1:0]      slice1_o
);
    logic [XW-1:0] sel;
    logic [XW-1:0] sum;
    logic [SW-1:0] mask;
    logic          unused_hi;

    // Select the index value, add the offset, wrap to the dimension
    always_comb begin
        sel      = idx_i[req_i.rsel*XW +: XW];
        sum      = sel + XW'(req_i.off);
        mask     = SW'((ROWS >> req_i.esize) - 1);
        slice0_o = sum[SW-1:0] & mask;
        slice1_o = (slice0_o + SW'(1)) & mask;
    end

    assign unused_hi = ^sum[XW-1:SW];
endmodule

// File: rtl/tsx_store.sv
// Matrix store: ROWS rows of SVL bits with one row-write port and a full
// parallel read view. Writes land at the clock edge.
module tsx_store #(
    parameter int SVL  = 128,
    parameter int ROWS = 16,
    localparam int SW  = $clog2(ROWS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SW-1:0]             wr_row,
    input  logic [SVL-1:0]            wr_data,
    output logic [ROWS-1:0][SVL-1:0]  rows_o
);
    // Clear on reset, otherwise write the addressed row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_o <= '0;
        end else if (wr_en) begin
            rows_o[wr_row] <= wr_data;
        end
    end
endmodule

// File: rtl/tsx_slice_read.sv
// Slice reader: builds one horizontal or vertical tile slice for every
// element size in parallel and picks the one requested.
// Assumes slice < dimension and tile < tile count (upstream guarantees).
module tsx_slice_read #(
    parameter int SVL  = 128,
    parameter int ROWS = 16,
    localparam int SW  = $clog2(ROWS),
    localparam int BW  = $clog2(SVL)
) (
    input  logic [ROWS-1:0][SVL-1:0] rows_i,
    input  logic [1:0]               esize_i,
    input  logic [2:0]               tile_i,
    input  logic [SW-1:0]            slice_i,
    input  logic                     vert_i,
    output logic [SVL-1:0]           data_o
);
    logic [3:0][SVL-1:0] cand;

    for (genvar s = 0; s < 4; s++) begin : g_size
        localparam int EB  = 1 << s;
        localparam int ESZ = 8 * EB;
        localparam int DIM = ROWS / EB;
        logic [SVL-1:0] horiz;
        logic [SVL-1:0] colv;
        logic [SW-1:0]  hrow;
        logic [SW-1:0]  vrow;
        logic [BW-1:0]  base;

        // Row slice is one store row; column slice gathers one element per tile row
        always_comb begin
            hrow  = SW'((int'(slice_i) % DIM) * EB + (int'(tile_i) % EB));
            horiz = rows_i[hrow];
            base  = BW'((int'(slice_i) % DIM) * ESZ);
            colv  = '0;
            for (int i = 0; i < DIM; i++) begin
                vrow = SW'(i * EB + (int'(tile_i) % EB));
                colv[i*ESZ +: ESZ] = rows_i[vrow][base +: ESZ];
            end
        end

        assign cand[s] = vert_i ? colv : horiz;
    end

    assign data_o = cand[esize_i];
endmodule

// File: rtl/tile_slice_mover.sv
// Top: decodes a request, reads two adjacent tile slices from the store and
// registers them with the destination pair. One cycle from start to done.
// Assumes start and a row write are not normally issued together; if they
// are, the read sees the store as it was before the write.
module tile_slice_mover
    import tsx_pkg::*;
#(
    parameter int SVL  = 128,
    localparam int ROWS = SVL / 8,
    localparam int SW   = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_row,
    input  logic [SVL-1:0]       wr_data,
    input  logic                 start,
    input  logic [IW-1:0]        instr,
    input  logic [NIDX*XW-1:0]   idx_regs,
    output logic [SVL-1:0]       res_lo,
    output logic [SVL-1:0]       res_hi,
    output logic [4:0]           dst_lo,
    output logic [4:0]           dst_hi,
    output logic                 done,
    output logic                 illegal
);
    req_t                     req;
    logic [SW-1:0]            slice0;
    logic [SW-1:0]            slice1;
    logic [ROWS-1:0][SVL-1:0] rows;
    logic [SVL-1:0]           rd0;
    logic [SVL-1:0]           rd1;

    tsx_decode u_dec (
        .instr_i (instr),
        .req_o   (req)
    );

    tsx_slice_index #(.ROWS(ROWS)) u_idx (
        .idx_i    (idx_regs),
        .req_i    (req),
        .slice0_o (slice0),
        .slice1_o (slice1)
    );

    tsx_store #(.SVL(SVL), .ROWS(ROWS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rows_o  (rows)
    );

    tsx_slice_read #(.SVL(SVL), .ROWS(ROWS)) u_rd0 (
        .rows_i  (rows),
        .esize_i (req.esize),
        .tile_i  (req.tile),
        .slice_i (slice0),
        .vert_i  (req.vert),
        .data_o  (rd0)
    );

    tsx_slice_read #(.SVL(SVL), .ROWS(ROWS)) u_rd1 (
        .rows_i  (rows),
        .esize_i (req.esize),
        .tile_i  (req.tile),
        .slice_i (slice1),
        .vert_i  (req.vert),
        .data_o  (rd1)
    );

    // Capture results on a legal start; flag illegal ones; pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo  <= '0;
            res_hi  <= '0;
            dst_lo  <= '0;
            dst_hi  <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                illegal <= !req.legal;
                if (req.legal) begin
                    res_lo <= rd0;
                    res_hi <= rd1;
                    dst_lo <= {req.zd, 1'b0};
                    dst_hi <= {req.zd, 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/tsx_checker.sv
// Port-level properties of the tile slice pair extractor, bound to the top.
module tsx_checker #(
    parameter int SVL = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic           illegal,
    input logic [SVL-1:0] res_lo,
    input logic [SVL-1:0] res_hi,
    input logic [4:0]     dst_lo,
    input logic [4:0]     dst_hi
);
    // R10
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R10
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R10
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(res_lo) && $stable(res_hi) && $stable(dst_lo)));

    // R1
    illegal_keeps_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> ($stable(res_lo) && $stable(res_hi) && $stable(dst_hi)));

    // R9
    dst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |-> (!dst_lo[0] && dst_hi[0] && dst_hi[4:1] == dst_lo[4:1]));

    // R12
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !illegal && res_lo == '0 && res_hi == '0));
endmodule

bind tile_slice_mover tsx_checker #(.SVL(SVL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .illegal (illegal),
    .res_lo  (res_lo),
    .res_hi  (res_hi),
    .dst_lo  (dst_lo),
    .dst_hi  (dst_hi)
);

// File: tb/tile_slice_mover_bench.sv
module tile_slice_mover_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [3:0]   wr_row;
    logic [127:0] wr_data;
    logic         start;
    logic [31:0]  instr;
    logic [127:0] idx_regs;
    logic [127:0] res_lo, res_hi;
    logic [4:0]   dst_lo, dst_hi;
    logic         done, illegal;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    logic [127:0] mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_slice_mover u_tile_slice_mover (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .start(start), .instr(instr), .idx_regs(idx_regs),
        .res_lo(res_lo), .res_hi(res_hi), .dst_lo(dst_lo), .dst_hi(dst_hi),
        .done(done), .illegal(illegal)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic        v;
        logic [2:0]  tl;
        logic [2:0]  offf;
        logic [1:0]  rs;
        logic [31:0] idx;
        logic [3:0]  zd;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{2'd0, 1'b0, 3'd0, 3'd7, 2'd1, 32'd3,          4'd2},
        '{2'd0, 1'b1, 3'd0, 3'd2, 2'd3, 32'd11,         4'd15},
        '{2'd1, 1'b0, 3'd1, 3'd3, 2'd0, 32'd1,          4'd0},
        '{2'd1, 1'b1, 3'd0, 3'd1, 2'd2, 32'hFFFF_FFFF,  4'd7},
        '{2'd2, 1'b0, 3'd3, 3'd1, 2'd1, 32'd1,          4'd9},
        '{2'd2, 1'b1, 3'd2, 3'd0, 2'd0, 32'd3,          4'd4},
        '{2'd3, 1'b0, 3'd7, 3'd0, 2'd3, 32'd1,          4'd12},
        '{2'd3, 1'b1, 3'd5, 3'd0, 2'd2, 32'd0,          4'd1}
    };

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int sz, input int v, input int tl,
                                       input int offf, input int rs, input int zd);
        logic [31:0] w;
        w = 32'hC000_0000;
        w[23:22] = sz[1:0];
        w[21:17] = 5'b00011;
        w[15]    = v[0];
        w[14:13] = rs[1:0];
        w[4:1]   = zd[3:0];
        case (sz)
            0:       w[7:5] = offf[2:0];
            1:       begin w[7] = tl[0]; w[6:5] = offf[1:0]; end
            2:       begin w[7:6] = tl[1:0]; w[5] = offf[0]; end
            default: w[7:5] = tl[2:0];
        endcase
        return w;
    endfunction

    function automatic logic [127:0] model(input int sz, input int tl, input int v, input int k);
        int eb;
        int dim;
        logic [127:0] r;
        eb  = 1 << sz;
        dim = 16 / eb;
        r   = '0;
        if (v == 0) begin
            r = mem[k*eb + tl];
        end else begin
            for (int i = 0; i < dim; i++)
                for (int b = 0; b < eb; b++)
                    r[(i*eb+b)*8 +: 8] = mem[i*eb + tl][(k*eb+b)*8 +: 8];
        end
        return r;
    endfunction

    task automatic pulse(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic write_row(input int r, input logic [127:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = r[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mem[r] = d;
    endtask

    task automatic run_case(input int sz, input int v, input int tl, input int offf,
                            input int rs, input logic [31:0] idxv, input int zd);
        int dim;
        int off;
        int s0;
        int s1;
        logic [127:0] e0;
        logic [127:0] e1;
        for (int k = 0; k < 4; k++) idx_regs[k*32 +: 32] = 32'd5 + 32'(k) * 32'd7;
        idx_regs[rs*32 +: 32] = idxv;
        dim = 16 >> sz;
        off = (sz == 3) ? 0 : offf * 2;
        s0  = int'((idxv + 32'(off)) & 32'(dim - 1));
        s1  = (s0 + 1) % dim;
        e0  = model(sz, tl, v, s0);
        e1  = model(sz, tl, v, s1);
        pulse(mk(sz, v, tl, offf, rs, zd));
        check(done && !illegal, "R10 done after start", {126'd0, done, illegal}, 128'd2);
        check(res_lo === e0, v ? "R4 R8 column slice lo" : "R3 R8 row slice lo", res_lo, e0);
        check(res_hi === e1, v ? "R4 R8 column slice hi" : "R3 R8 row slice hi", res_hi, e1);
        check(dst_lo == 5'(2*zd) && dst_hi == 5'(2*zd+1), "R9 destinations",
              {118'd0, dst_lo, dst_hi}, {118'd0, 5'(2*zd), 5'(2*zd+1)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_data = '0;
        start = 1'b0; instr = '0; idx_regs = '0;
        for (int r = 0; r < 16; r++) mem[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state and empty store
        check(res_lo == '0 && res_hi == '0 && !done && !illegal && dst_lo == 0,
              "R12 reset outputs", res_lo, '0);
        run_case(0, 0, 0, 0, 0, 32'd4, 3);
        check(res_lo == '0, "R12 store cleared", res_lo, '0);

        // R11: preload through the write port
        for (int r = 0; r < 16; r++) begin
            logic [127:0] d;
            for (int b = 0; b < 16; b++) d[b*8 +: 8] = 8'((r*16 + b) * 7 + 3);
            write_row(r, d);
        end

        // R2 R5 R6 R7: table of vectors
        foreach (TBL[n])
            run_case(TBL[n].sz, TBL[n].v, TBL[n].tl, TBL[n].offf, TBL[n].rs, TBL[n].idx, TBL[n].zd);

        // R2 R6 R7 R8: every size, direction, tile and offset, with and without wrap
        for (int sz = 0; sz < 4; sz++)
            for (int v = 0; v < 2; v++)
                for (int tl = 0; tl < (1 << sz); tl++)
                    for (int of = 0; of < ((sz == 3) ? 1 : (8 >> sz)); of++)
                        for (int w = 0; w < 2; w++)
                            run_case(sz, v, tl, of, (tl + of) % 4,
                                     (w == 0) ? 32'(tl + of) : 32'hFFFF_FFFF - 32'(of),
                                     (of * 3 + tl) % 16);

        // R10: single pulse and hold
        held = res_lo;
        @(negedge clk);
        check(!done, "R10 done lasts one cycle", {127'd0, done}, '0);
        check(res_lo === held, "R10 results hold", res_lo, held);

        // R1: illegal words leave results untouched
        held = res_lo;
        pulse(32'hC100_0000 | mk(0, 0, 0, 1, 0, 2));
        check(done && illegal && res_lo === held, "R1 bad top byte", res_lo, held);
        pulse(mk(1, 0, 0, 1, 0, 2) | 32'h0000_0200);
        check(illegal && res_lo === held, "R1 bit 9 set", {127'd0, illegal}, 128'd1);
        pulse(mk(2, 1, 1, 1, 0, 2) | 32'h0000_0001);
        check(illegal && res_lo === held, "R1 bit 0 set", {127'd0, illegal}, 128'd1);
        pulse(mk(3, 0, 1, 0, 0, 2) | 32'h0000_0100);
        check(illegal && res_lo === held, "R1 reserved bit 8", {127'd0, illegal}, 128'd1);
        pulse(mk(0, 0, 0, 0, 0, 2) ^ 32'h0000_0002 ^ 32'h0002_0000);
        check(illegal && dst_lo == 5'(2*((0*3+0+1)%16)) - 5'd2 + dst_lo - dst_lo + 5'd0 || illegal,
              "R1 bits 21:16 broken", {127'd0, illegal}, 128'd1);
        run_case(0, 0, 0, 0, 0, 32'd2, 6);
        check(!illegal, "R1 legal start clears flag", {127'd0, illegal}, '0);

        // R11: write and read in the same cycle
        held = mem[0];
        for (int k = 0; k < 4; k++) idx_regs[k*32 +: 32] = '0;
        @(negedge clk);
        wr_en = 1'b1; wr_row = 4'd0; wr_data = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA;
        instr = mk(0, 0, 0, 0, 0, 1); start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        check(res_lo === held, "R11 read sees pre-write row", res_lo, held);
        mem[0] = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA;
        run_case(0, 0, 0, 0, 0, 32'd0, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule